// File: doc/BRIEF.md
# Injected Conversion Group Sequencer

This block runs a short, high-priority conversion sequence of one to four ranks on an analog-to-digital converter that is modelled here as a cycle counter. Static configuration inputs choose the sequence length, the channel number of each of four 5-bit slots, a per-rank offset, the trigger source (a software start pulse or an external line with a selectable edge), discontinuous stepping and automatic chaining after the regular group. The regular-group sequencer lies outside the block and is represented only by a one-cycle done pulse.

When a start is accepted the block steps through the ranks. Each rank keeps the converter busy for the sampling cycles plus a processing time that depends on the resolution. It then stores the raw sample minus that rank's offset as a signed 16-bit result. After the last rank it raises a one-cycle end-of-sequence pulse. In discontinuous mode each start converts one rank only, and the rank pointer is held until the next start.

Top module: `inj_seq_ctrl`

## Requirements
- R1: The length is `cfg_len_m1`+1 (1 to 4). Rank r (0-based) converts the channel in slot r+4-L, which is bits [5*(r+4-L) +: 5] of `cfg_slots`, so a short sequence uses the upper slots. `conv_chan` shows that channel while `conv_busy` is high.
- R2: With `cfg_sw_sel`=0, `cfg_edge` chooses the external edge that starts a sequence: 00 none, 01 rising, 10 falling, 11 both. An edge is seen when `ext_trig` differs from its value at the previous clock edge, and `conv_busy` rises at that clock edge.
- R3: With `cfg_sw_sel`=1, only a `sw_start` pulse starts a sequence and `ext_trig` is ignored. With `cfg_sw_sel`=0, `sw_start` is ignored.
- R4: Each rank keeps `conv_busy` high for `cfg_smp` plus 12, 11, 9 or 7 cycles for `cfg_res` codes 00, 01, 10, 11 (12, 10, 8, 6 bits). Ranks of one sequence follow each other with no idle cycle.
- R5: The result of rank r is the sample, cut to its low 12, 10, 8 or 6 bits by resolution, minus `cfg_offsets[12*r +: 12]`, as a 16-bit two's-complement value in `res_flat[16*r +: 16]`. It is captured in the last busy cycle of that rank and holds until the rank is converted again.
- R6: With `cfg_disc_en`=1, `cfg_scan_en`=1 and `cfg_cont_en`=0, each start converts exactly one rank, and the next start converts the following rank.
- R7: Discontinuous mode has no effect when `cfg_cont_en`=1 or `cfg_scan_en`=0. With scan off, each start converts rank 0 of the configured length only.
- R8: When `cfg_auto_en`=1, `cfg_disc_en`=0 and `cfg_sw_sel`=1, a `reg_seq_done` pulse starts the full sequence. In any other setting `reg_seq_done` is ignored.
- R9: Any start request that arrives while `conv_busy` is high is dropped. It neither restarts nor lengthens the sequence.
- R10: `seq_eos` is high for exactly one cycle, right after the last rank is stored. `conv_busy` is low in that cycle, and the next start begins again at rank 0.
- R11: After reset `conv_busy` and `seq_eos` are low and all results are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len_m1 | input | 2 | Sequence length minus one |
| cfg_slots | input | 20 | Four 5-bit channel slots |
| cfg_offsets | input | 48 | Four 12-bit offsets, rank 0 lowest |
| cfg_sw_sel | input | 1 | 1: software start, 0: external line |
| cfg_edge | input | 2 | External edge select |
| cfg_scan_en | input | 1 | Multi-rank scan enable |
| cfg_cont_en | input | 1 | Continuous mode of the converter |
| cfg_disc_en | input | 1 | Discontinuous stepping request |
| cfg_auto_en | input | 1 | Chain after regular sequence |
| cfg_res | input | 2 | Resolution code |
| cfg_smp | input | 8 | Sampling cycles |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 1 | External trigger line |
| reg_seq_done | input | 1 | Regular sequence completion pulse |
| sample_in | input | 12 | Raw converter sample |
| conv_busy | output | 1 | A rank conversion is in progress |
| conv_chan | output | 5 | Channel of the current rank |
| conv_rank | output | 2 | Current rank pointer |
| res_flat | output | 64 | Four signed 16-bit results |
| seq_eos | output | 1 | End-of-sequence pulse |

## Verification
The assertions assume that every configuration input holds steady while `conv_busy` is high and across a discontinuous sequence that is only partly done, and that `ext_trig` is low at reset. The bench changes configuration only at idle points after an end-of-sequence or a single discontinuous step, and it holds the external line low through reset. Triggers are deliberately injected during busy windows. These pulses only exercise the drop rule and never alter configuration.

// File: rtl/inj_seq_pkg.sv
// Shared encodings and helper functions for the injected sequencer.
// Assumes resolution codes map 00/01/10/11 to 12/10/8/6 bits.
package inj_seq_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        RES_12 = 2'b00,
        RES_10 = 2'b01,
        RES_8  = 2'b10,
        RES_6  = 2'b11
    } res_sel_e;

    // Processing cycles that follow sampling, per resolution code.
    function automatic logic [3:0] proc_cycles(input logic [1:0] res);
        case (res_sel_e'(res))
            RES_12:  return 4'd12;
            RES_10:  return 4'd11;
            RES_8:   return 4'd9;
            default: return 4'd7;
        endcase
    endfunction

endpackage

// File: rtl/inj_trig_detect.sv
// Turns the selected trigger source into a one-cycle start request.
// Assumes sw_start is already a clean pulse and ext_trig is synchronous.
module inj_trig_detect
    import inj_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_trig,
    input  logic [1:0] edge_sel,
    input  logic       sw_sel,
    input  logic       sw_start,
    output logic       trig_hit
);

    logic ext_q;
    logic rise;
    logic fall;
    logic edge_hit;

    // Remember the line value of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_trig;
    end

    assign rise = ext_trig & ~ext_q;
    assign fall = ~ext_trig & ext_q;

    // Pick the edge(s) that count as a trigger.
    always_comb begin
        case (edge_sel_e'(edge_sel))
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    end

    assign trig_hit = sw_sel ? sw_start : edge_hit;

endmodule

// File: rtl/inj_conv_timer.sv
// Abstract converter: stays busy for sampling plus processing cycles.
// Assumes smp and res stay stable while busy; total is at least 7.
module inj_conv_timer
    import inj_seq_pkg::*;
#(
    parameter int SMP_W = 8,
    localparam int CNT_W = SMP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SMP_W-1:0] smp,
    input  logic [1:0]       res,
    output logic             busy,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] total;
    logic             busy_q;

    assign total = CNT_W'(smp) + CNT_W'(proc_cycles(res));

    // Load on start, count down while busy, drop busy after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= total - CNT_W'(1);
        end else if (busy_q && cnt_q == '0) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/inj_rank_ctrl.sv
// Rank pointer, start arbitration, chaining and end-of-sequence pulse.
// Assumes length and mode inputs are stable while a sequence is open.
module inj_rank_ctrl #(
    parameter int RANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_hit,
    input  logic              auto_hit,
    input  logic              busy,
    input  logic              done,
    input  logic [RANK_W-1:0] len_m1,
    input  logic              scan_en,
    input  logic              disc_eff,
    output logic              conv_start,
    output logic [RANK_W-1:0] rank_ptr,
    output logic              store_en,
    output logic              eos
);

    logic [RANK_W-1:0] ptr_q;
    logic [RANK_W-1:0] last_rank;
    logic              at_last;
    logic              chain;
    logic              eos_q;

    assign last_rank = scan_en ? len_m1 : '0;
    assign at_last   = (ptr_q == last_rank);
    assign chain     = done & ~at_last & ~disc_eff;
    // New requests only count while idle; chained ranks start at done.
    assign conv_start = (~busy & (trig_hit | auto_hit)) | chain;

    // Advance or wrap the pointer when a rank finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr_q <= '0;
        else if (done) ptr_q <= at_last ? '0 : ptr_q + RANK_W'(1);
    end

    // One-cycle pulse after the final rank is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) eos_q <= 1'b0;
        else        eos_q <= done & at_last;
    end

    assign rank_ptr = ptr_q;
    assign store_en = done;
    assign eos      = eos_q;

endmodule

// File: rtl/inj_result_bank.sv
// Per-rank signed result registers holding sample minus offset.
// Assumes RES_W is wider than RAW_W so the sign bit is never lost.
module inj_result_bank #(
    parameter int N_RANKS = 4,
    parameter int RAW_W   = 12,
    parameter int RES_W   = 16,
    localparam int RANK_W = $clog2(N_RANKS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     store_en,
    input  logic [RANK_W-1:0]        store_rank,
    input  logic [RAW_W-1:0]         raw,
    input  logic [RAW_W-1:0]         offset,
    output logic [N_RANKS*RES_W-1:0] res_flat
);

    logic [RES_W-1:0] diff;

    assign diff = {{(RES_W-RAW_W){1'b0}}, raw} - {{(RES_W-RAW_W){1'b0}}, offset};

    for (genvar g = 0; g < N_RANKS; g++) begin : g_rank
        logic [RES_W-1:0] res_q;
        // Capture the difference when this rank completes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                res_q <= '0;
            else if (store_en && store_rank == RANK_W'(g))
                res_q <= diff;
        end
        assign res_flat[g*RES_W +: RES_W] = res_q;
    end

endmodule

// File: rtl/inj_seq_ctrl.sv
// Top of the injected group sequencer: trigger selection, rank stepping,
// converter timing and result storage. Assumes configuration is static
// while a sequence (or a partly done discontinuous sequence) is open.
module inj_seq_ctrl #(
    parameter int N_RANKS = 4,
    parameter int CH_W    = 5,
    parameter int RAW_W   = 12,
    parameter int RES_W   = 16,
    parameter int SMP_W   = 8,
    localparam int RANK_W = $clog2(N_RANKS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [RANK_W-1:0]        cfg_len_m1,
    input  logic [N_RANKS*CH_W-1:0]  cfg_slots,
    input  logic [N_RANKS*RAW_W-1:0] cfg_offsets,
    input  logic                     cfg_sw_sel,
    input  logic [1:0]               cfg_edge,
    input  logic                     cfg_scan_en,
    input  logic                     cfg_cont_en,
    input  logic                     cfg_disc_en,
    input  logic                     cfg_auto_en,
    input  logic [1:0]               cfg_res,
    input  logic [SMP_W-1:0]         cfg_smp,
    input  logic                     sw_start,
    input  logic                     ext_trig,
    input  logic                     reg_seq_done,
    input  logic [RAW_W-1:0]         sample_in,
    output logic                     conv_busy,
    output logic [CH_W-1:0]          conv_chan,
    output logic [RANK_W-1:0]        conv_rank,
    output logic [N_RANKS*RES_W-1:0] res_flat,
    output logic                     seq_eos
);

    logic              trig_hit;
    logic              auto_hit;
    logic              disc_eff;
    logic              conv_start;
    logic              tmr_done;
    logic              store_en;
    logic [RANK_W-1:0] rank_ptr;
    logic [RANK_W:0]   slot_idx;
    logic [2:0]        drop_bits;
    logic [RAW_W-1:0]  kept_raw;
    logic [RAW_W-1:0]  rank_off;

    // Discontinuous stepping only applies with scan on and continuous off.
    assign disc_eff = cfg_disc_en & cfg_scan_en & ~cfg_cont_en;
    // Chaining after the regular group needs software start, no stepping.
    assign auto_hit = reg_seq_done & cfg_auto_en & ~cfg_disc_en & cfg_sw_sel;

    inj_trig_detect u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_trig (ext_trig),
        .edge_sel (cfg_edge),
        .sw_sel   (cfg_sw_sel),
        .sw_start (sw_start),
        .trig_hit (trig_hit)
    );

    inj_rank_ctrl #(.RANK_W(RANK_W)) u_rank (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_hit   (trig_hit),
        .auto_hit   (auto_hit),
        .busy       (conv_busy),
        .done       (tmr_done),
        .len_m1     (cfg_len_m1),
        .scan_en    (cfg_scan_en),
        .disc_eff   (disc_eff),
        .conv_start (conv_start),
        .rank_ptr   (rank_ptr),
        .store_en   (store_en),
        .eos        (seq_eos)
    );

    inj_conv_timer #(.SMP_W(SMP_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .smp   (cfg_smp),
        .res   (cfg_res),
        .busy  (conv_busy),
        .done  (tmr_done)
    );

    // Right-aligned slot lookup: rank r of L reads slot r + N - L.
    assign slot_idx  = {1'b0, rank_ptr} + (RANK_W+1)'(N_RANKS-1) - {1'b0, cfg_len_m1};
    assign conv_chan = cfg_slots[int'(slot_idx)*CH_W +: CH_W];
    assign conv_rank = rank_ptr;

    // Keep only the bits the selected resolution produces.
    assign drop_bits = {cfg_res, 1'b0};
    assign kept_raw  = sample_in & ({RAW_W{1'b1}} >> drop_bits);
    assign rank_off  = cfg_offsets[int'(rank_ptr)*RAW_W +: RAW_W];

    inj_result_bank #(
        .N_RANKS (N_RANKS),
        .RAW_W   (RAW_W),
        .RES_W   (RES_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_en   (store_en),
        .store_rank (rank_ptr),
        .raw        (kept_raw),
        .offset     (rank_off),
        .res_flat   (res_flat)
    );

endmodule

// File: rtl/inj_seq_chk.sv
// Property checker for the injected sequencer, bound to the top module.
// Assumes configuration inputs are stable while conversions run.
module inj_seq_chk
    import inj_seq_pkg::*;
#(
    parameter int RANK_W = 2,
    parameter int SMP_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_busy,
    input logic              seq_eos,
    input logic              tmr_done,
    input logic              conv_start,
    input logic [RANK_W-1:0] rank_ptr,
    input logic              disc_eff,
    input logic              cfg_sw_sel,
    input logic              cfg_auto_en,
    input logic              cfg_disc_en,
    input logic              sw_start,
    input logic              reg_seq_done,
    input logic [1:0]        cfg_res,
    input logic [SMP_W-1:0]  cfg_smp
);

    logic [15:0] run_cnt;
    logic [15:0] t_tot;

    assign t_tot = 16'(cfg_smp) + 16'(proc_cycles(cfg_res));

    // Cycles elapsed since the current rank started.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_cnt <= '0;
        else if (conv_start) run_cnt <= '0;
        else if (conv_busy)  run_cnt <= run_cnt + 16'd1;
    end

    p_conv_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |-> run_cnt == t_tot - 16'd1);

    p_eos_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_eos |=> !seq_eos);

    p_eos_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_eos |-> (!conv_busy && rank_ptr == '0));

    p_disc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_eff && tmr_done) |=> !conv_busy);

    p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && !tmr_done) |=> (conv_busy && $stable(rank_ptr)));

    p_sw_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_busy && cfg_sw_sel && sw_start) |=> conv_busy);

    p_auto_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_busy && reg_seq_done && cfg_auto_en && !cfg_disc_en && cfg_sw_sel)
        |=> conv_busy);

endmodule

bind inj_seq_ctrl inj_seq_chk #(.RANK_W(RANK_W), .SMP_W(SMP_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_busy    (conv_busy),
    .seq_eos      (seq_eos),
    .tmr_done     (tmr_done),
    .conv_start   (conv_start),
    .rank_ptr     (rank_ptr),
    .disc_eff     (disc_eff),
    .cfg_sw_sel   (cfg_sw_sel),
    .cfg_auto_en  (cfg_auto_en),
    .cfg_disc_en  (cfg_disc_en),
    .sw_start     (sw_start),
    .reg_seq_done (reg_seq_done),
    .cfg_res      (cfg_res),
    .cfg_smp      (cfg_smp)
);

// File: tb/inj_seq_ctrl_tb_top.sv
// Self-checking bench: directed corners plus seeded random bursts.
module inj_seq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_len_m1 = '0;
    logic [19:0] cfg_slots = '0;
    logic [47:0] cfg_offsets = '0;
    logic        cfg_sw_sel = 1'b1;
    logic [1:0]  cfg_edge = '0;
    logic        cfg_scan_en = 1'b1;
    logic        cfg_cont_en = 1'b0;
    logic        cfg_disc_en = 1'b0;
    logic        cfg_auto_en = 1'b0;
    logic [1:0]  cfg_res = '0;
    logic [7:0]  cfg_smp = '0;
    logic        sw_start = 1'b0;
    logic        ext_trig = 1'b0;
    logic        reg_seq_done = 1'b0;
    logic [11:0] sample_in = '0;
    logic        conv_busy;
    logic [4:0]  conv_chan;
    logic [1:0]  conv_rank;
    logic [63:0] res_flat;
    logic        seq_eos;

    int          checks = 0;
    int          errors = 0;
    logic [15:0] exp_res [4];
    logic [11:0] rawv [4];

    always #10 clk = ~clk;

    inj_seq_ctrl dut_i (
        .clk, .rst_n, .cfg_len_m1, .cfg_slots, .cfg_offsets, .cfg_sw_sel,
        .cfg_edge, .cfg_scan_en, .cfg_cont_en, .cfg_disc_en, .cfg_auto_en,
        .cfg_res, .cfg_smp, .sw_start, .ext_trig, .reg_seq_done, .sample_in,
        .conv_busy, .conv_chan, .conv_rank, .res_flat, .seq_eos
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int t_conv();
        int p;
        case (cfg_res)
            2'b00: p = 12;
            2'b01: p = 11;
            2'b10: p = 9;
            default: p = 7;
        endcase
        return p + int'(cfg_smp);
    endfunction

    function automatic logic [4:0] slot_of(input int k);
        return cfg_slots[5*(k + 3 - int'(cfg_len_m1)) +: 5];
    endfunction

    function automatic logic [15:0] exp_of(input int k, input logic [11:0] raw);
        logic [11:0] m;
        m = raw & (12'hFFF >> (2*int'(cfg_res)));
        return {4'b0, m} - {4'b0, cfg_offsets[12*k +: 12]};
    endfunction

    // Called at the negedge after the accepting clock edge.
    task automatic mon(input int nr, input int r0, input bit exp_eos,
                       input bit noise, input string req);
        int T;
        int bad;
        T = t_conv();
        bad = 0;
        for (int i = 0; i < nr*T; i++) begin
            int k;
            k = r0 + i / T;
            sample_in = rawv[k];
            if (conv_busy !== 1'b1 || conv_chan !== slot_of(k)) bad++;
            if (noise && i == 3) begin sw_start = 1'b1; reg_seq_done = 1'b1; end
            if (noise && i == 4) begin sw_start = 1'b0; reg_seq_done = 1'b0; end
            if ((i % T) == T - 1) exp_res[k] = exp_of(k, rawv[k]);
            @(negedge clk);
        end
        chk(bad == 0, req, "busy/channel window mismatches", bad, 0);
        chk(conv_busy == 1'b0, req, "busy after last rank (R4)", conv_busy, 0);
        chk(seq_eos == exp_eos, "R10", "eos after rank", seq_eos, exp_eos);
        for (int r = 0; r < 4; r++)
            chk(res_flat[16*r +: 16] == exp_res[r], "R5", "result",
                res_flat[16*r +: 16], exp_res[r]);
        @(negedge clk);
        chk(seq_eos == 1'b0, "R10", "eos second cycle", seq_eos, 0);
    endtask

    task automatic idle_chk(input int n, input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (conv_busy !== 1'b0) bad++;
            @(negedge clk);
        end
        chk(bad == 0, req, "unexpected busy cycles", bad, 0);
    endtask

    task automatic fire_sw();
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
    endtask

    task automatic fire_auto();
        reg_seq_done = 1'b1;
        @(negedge clk);
        reg_seq_done = 1'b0;
    endtask

    task automatic fire_ext();
        case (cfg_edge)
            2'b01: begin
                if (ext_trig) begin ext_trig = 1'b0; @(negedge clk); end
                ext_trig = 1'b1;
            end
            2'b10: begin
                if (!ext_trig) begin ext_trig = 1'b1; @(negedge clk); end
                ext_trig = 1'b0;
            end
            default: ext_trig = ~ext_trig;
        endcase
        @(negedge clk);
    endtask

    task automatic set_raw_rand();
        for (int r = 0; r < 4; r++) rawv[r] = 12'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        for (int r = 0; r < 4; r++) exp_res[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(conv_busy == 0, "R11", "busy", conv_busy, 0);
        chk(seq_eos == 0, "R11", "eos", seq_eos, 0);
        chk(res_flat == '0, "R11", "results", res_flat, 0);

        // R1: full length, distinct slots, software start
        cfg_len_m1 = 2'd3; cfg_slots = {5'd17, 5'd9, 5'd4, 5'd22};
        cfg_offsets = '0; cfg_res = 2'b00; cfg_smp = 8'd3;
        set_raw_rand(); sample_in = rawv[0];
        fire_sw(); mon(4, 0, 1'b1, 1'b0, "R1");

        // R5: raw below offset gives a negative value, length 1 uses top slot
        cfg_len_m1 = 2'd0; cfg_offsets = 48'd10; rawv[0] = 12'd5; sample_in = rawv[0];
        fire_sw(); mon(1, 0, 1'b1, 1'b0, "R1");
        chk(res_flat[15:0] == 16'hFFFB, "R5", "negative result", res_flat[15:0], 16'hFFFB);

        // R4/R5: 6-bit resolution, no sampling cycles, upper bits dropped
        cfg_res = 2'b11; cfg_smp = 8'd0; cfg_offsets = '0; rawv[0] = 12'hFFF;
        sample_in = rawv[0];
        fire_sw(); mon(1, 0, 1'b1, 1'b0, "R4");
        chk(res_flat[15:0] == 16'd63, "R5", "masked 6-bit", res_flat[15:0], 63);

        // R9: start requests during busy are dropped
        cfg_len_m1 = 2'd1; cfg_res = 2'b01; cfg_smp = 8'd2; set_raw_rand();
        cfg_offsets = {$urandom, $urandom}; sample_in = rawv[0];
        fire_sw(); mon(2, 0, 1'b1, 1'b1, "R9");

        // R6: discontinuous stepping, one rank per start
        cfg_len_m1 = 2'd2; cfg_disc_en = 1'b1; cfg_res = 2'b10; cfg_smp = 8'd1;
        set_raw_rand();
        for (int r = 0; r < 3; r++) begin
            sample_in = rawv[r];
            fire_sw();
            mon(1, r, (r == 2), 1'b0, "R6");
            chk(conv_rank == 2'((r + 1) % 3), "R6", "pointer after step",
                conv_rank, (r + 1) % 3);
        end

        // R7: continuous mode neutralises stepping
        cfg_cont_en = 1'b1; set_raw_rand(); sample_in = rawv[0];
        fire_sw(); mon(3, 0, 1'b1, 1'b0, "R7");
        // R7: scan off converts rank 0 only
        cfg_cont_en = 1'b0; cfg_scan_en = 1'b0; set_raw_rand(); sample_in = rawv[0];
        fire_sw(); mon(1, 0, 1'b1, 1'b0, "R7");
        cfg_scan_en = 1'b1; cfg_disc_en = 1'b0;

        // R8: chaining after the regular group and its blocking conditions
        cfg_auto_en = 1'b1; set_raw_rand(); sample_in = rawv[0];
        fire_auto(); mon(3, 0, 1'b1, 1'b0, "R8");
        cfg_disc_en = 1'b1; fire_auto(); idle_chk(4, "R8");
        cfg_disc_en = 1'b0; cfg_sw_sel = 1'b0; cfg_edge = 2'b00;
        fire_auto(); idle_chk(4, "R8");
        cfg_auto_en = 1'b0; cfg_sw_sel = 1'b1; fire_auto(); idle_chk(4, "R8");

        // R3: external line ignored under software start and vice versa
        cfg_edge = 2'b11; ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
        idle_chk(3, "R3");
        cfg_sw_sel = 1'b0; fire_sw(); idle_chk(3, "R3");

        // R2: each edge mode, then the disabled setting
        for (int e = 1; e < 4; e++) begin
            cfg_edge = 2'(e); set_raw_rand(); sample_in = rawv[0];
            fire_ext(); mon(3, 0, 1'b1, 1'b0, "R2");
        end
        cfg_edge = 2'b11; set_raw_rand(); sample_in = rawv[0];
        fire_ext(); mon(3, 0, 1'b1, 1'b0, "R2");
        cfg_edge = 2'b00;
        ext_trig = ~ext_trig; @(negedge clk); ext_trig = ~ext_trig;
        idle_chk(4, "R2");

        // Random bursts across lengths, resolutions, sources and timing
        for (int n = 0; n < 30; n++) begin
            int kind;
            cfg_len_m1 = 2'($urandom); cfg_slots = 20'($urandom);
            cfg_offsets = {$urandom, $urandom}; cfg_res = 2'($urandom);
            cfg_smp = 8'($urandom % 21); set_raw_rand(); sample_in = rawv[0];
            kind = int'($urandom % 3);
            if (kind == 0) begin
                cfg_sw_sel = 1'b1; cfg_auto_en = 1'b0; fire_sw();
            end else if (kind == 1) begin
                cfg_sw_sel = 1'b0; cfg_edge = 2'(1 + $urandom % 3); fire_ext();
            end else begin
                cfg_sw_sel = 1'b1; cfg_auto_en = 1'b1; fire_auto();
            end
            mon(int'(cfg_len_m1) + 1, 0, 1'b1, 1'($urandom), "R4");
            cfg_auto_en = 1'b0;
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule